// File: doc/BRIEF.md
# Dual-Channel Third-Order Loop Compensator

This block is the digital filter in a power-converter control loop that serves two regulated outputs through one inductor, one ADC and one pulse-width modulator. Once per switching period a 6-bit conversion result arrives with a valid strobe and a channel-select bit. The block forms the error between the reference code and that sample. It runs the error through a fixed-point three-pole, three-zero recursion that keeps its own input and output history for each channel, adds the reference code back, and clamps the result into a programmable duty window. The clamped 6-bit code drives the modulator.

The two channels are interleaved. Select 0 serves the first output and select 1 the second, in alternate periods. Only the history of the channel being served moves. Until the start strobe has been seen, the block ignores samples and presents the reference code, so the modulator never sees a zero duty during power-up.

Top module: `loop_comp3`

## Requirements
- R1: While rst_ni is low, duty_o is 0 and all filter history of both channels is cleared.
- R2: Before start has been seen, duty_o equals the ref_code_i value of the previous clock, and samples leave the history untouched.
- R3: A start_i pulse takes effect from the next clock and stays in effect until reset. After it, duty_o keeps the last reference value until the first accepted sample.
- R4: The filter input is the signed error u = ref_code_i − sample_i, with both codes read as unsigned.
- R5: The recursion is y(n) = 12227·u(n) − 11043·u(n−1) − 12200·u(n−2) + 11072·u(n−3) + floor((8038·y(n−1) − 4890·y(n−2) + 948·y(n−3)) / 4096). Here y is held with 12 fraction bits and the coefficients are the filter values scaled by 4096.
- R6: chan_sel_i = 0 selects channel 0 and 1 selects channel 1. An accepted sample reads and updates only the selected channel's history.
- R7: y saturates to the range −2097152 to 2097151 and never wraps. The saturated value is what enters the history.
- R8: The pre-clamp value is ref_code_i + floor(y(n) / 4096).
- R9: The clamp tests the high limit first. A value above lim_hi_i gives lim_hi_i. Otherwise a value below lim_lo_i gives lim_lo_i. Otherwise the value passes unchanged.
- R10: Once running, duty_o changes only on the clock edge that accepts a sample (sample_valid_i high). Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, enables closed-loop operation |
| chan_sel_i | input | 1 | Channel of the current sample (0 or 1) |
| sample_valid_i | input | 1 | Sample strobe, one per switching period |
| sample_i | input | 6 | Converted output-voltage code |
| ref_code_i | input | 6 | Reference code |
| lim_hi_i | input | 6 | Upper duty limit |
| lim_lo_i | input | 6 | Lower duty limit |
| duty_o | output | 6 | Clamped duty code |

## Verification
Every result is due exactly one clock after the edge that causes it. A sample accepted at a rising edge shows its clamped duty code after that edge. Before start, the reference code seen at an edge appears after that same edge. The reference model therefore advances on the same rising edge as the design, and the output is compared on the following falling edge of every clock, including idle clocks, where the hold behaviour is checked. Long runs with a constant error drive the recursion's integrating pole into saturation, and the error is then reversed to show that recovery does not wrap.

// File: rtl/lc3_pkg.sv
package lc3_pkg;
  localparam int unsigned NCH = 2;
  localparam int unsigned NTAP_U = 4;
  localparam int unsigned NTAP_Y = 3;
  // numerator, u(n)..u(n-3), Q12
  localparam int B_COEF [NTAP_U] = '{12227, -11043, -12200, 11072};
  // feedback terms already carrying their sign, y(n-1)..y(n-3), Q12
  localparam int A_COEF [NTAP_Y] = '{8038, -4890, 948};
endpackage

// File: rtl/lc3_history.sv
module lc3_history #(
  parameter int unsigned UW = 7,
  parameter int unsigned YW = 22
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic signed [UW-1:0] u_i,
  input  logic signed [YW-1:0] y_i,
  output logic signed [UW-1:0] u_hist_o [lc3_pkg::NTAP_Y],
  output logic signed [YW-1:0] y_hist_o [lc3_pkg::NTAP_Y]
);
  localparam int unsigned D = lc3_pkg::NTAP_Y;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < D; k++) begin
        u_hist_o[k] <= '0;
        y_hist_o[k] <= '0;
      end
    end else if (we_i) begin
      u_hist_o[0] <= u_i;
      y_hist_o[0] <= y_i;
      for (int k = 1; k < D; k++) begin
        u_hist_o[k] <= u_hist_o[k-1];
        y_hist_o[k] <= y_hist_o[k-1];
      end
    end
  end
endmodule

// File: rtl/lc3_mac.sv
module lc3_mac #(
  parameter int unsigned UW   = 7,
  parameter int unsigned YW   = 22,
  parameter int unsigned FRAC = 12,
  parameter int unsigned AW   = 48
) (
  input  logic signed [UW-1:0] u_i,
  input  logic signed [UW-1:0] u_hist_i [lc3_pkg::NTAP_Y],
  input  logic signed [YW-1:0] y_hist_i [lc3_pkg::NTAP_Y],
  output logic signed [YW-1:0] y_o
);
  import lc3_pkg::*;

  localparam longint YMAX_L = (64'sd1 <<< (YW - 1)) - 64'sd1;
  localparam longint YMIN_L = -(64'sd1 <<< (YW - 1));
  localparam logic signed [AW-1:0] YMAX = AW'(YMAX_L);
  localparam logic signed [AW-1:0] YMIN = AW'(YMIN_L);

  logic signed [AW-1:0] fwd, fbk, acc;

  always_comb begin
    fwd = AW'(B_COEF[0]) * AW'(u_i);
    for (int k = 1; k < NTAP_U; k++) begin
      fwd = fwd + AW'(B_COEF[k]) * AW'(u_hist_i[k-1]);
    end
    fbk = '0;
    for (int k = 0; k < NTAP_Y; k++) begin
      fbk = fbk + AW'(A_COEF[k]) * AW'(y_hist_i[k]);
    end
    acc = fwd + (fbk >>> FRAC);
    if (acc > YMAX)      y_o = YW'(YMAX);
    else if (acc < YMIN) y_o = YW'(YMIN);
    else                 y_o = YW'(acc);
  end
endmodule

// File: rtl/lc3_clamp.sv
module lc3_clamp #(
  parameter int unsigned DW   = 6,
  parameter int unsigned YW   = 22,
  parameter int unsigned FRAC = 12
) (
  input  logic signed [YW-1:0] y_i,
  input  logic        [DW-1:0] ref_i,
  input  logic        [DW-1:0] hi_i,
  input  logic        [DW-1:0] lo_i,
  output logic        [DW-1:0] duty_o
);
  localparam int unsigned VW = YW + 2;

  logic signed [YW-1:0] y_int;
  logic signed [VW-1:0] val, hi_w, lo_w;

  assign y_int = y_i >>> FRAC;
  assign val   = VW'(y_int) + VW'($signed({1'b0, ref_i}));
  assign hi_w  = VW'($signed({1'b0, hi_i}));
  assign lo_w  = VW'($signed({1'b0, lo_i}));

  // high limit has priority when the window is inverted
  always_comb begin
    if (val > hi_w)      duty_o = hi_i;
    else if (val < lo_w) duty_o = lo_i;
    else                 duty_o = DW'(val);
  end
endmodule

// File: rtl/loop_comp3.sv
module loop_comp3 #(
  parameter int unsigned DW   = 6,
  parameter int unsigned FRAC = 12,
  parameter int unsigned YW   = 22,
  parameter int unsigned AW   = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          chan_sel_i,
  input  logic          sample_valid_i,
  input  logic [DW-1:0] sample_i,
  input  logic [DW-1:0] ref_code_i,
  input  logic [DW-1:0] lim_hi_i,
  input  logic [DW-1:0] lim_lo_i,
  output logic [DW-1:0] duty_o
);
  import lc3_pkg::*;

  localparam int unsigned UW = DW + 1;

  logic                 running_q;
  logic                 acc_en;
  logic signed [UW-1:0] u_now;
  logic signed [YW-1:0] y_new;
  logic        [DW-1:0] duty_d;

  logic signed [UW-1:0] u_h [NCH][NTAP_Y];
  logic signed [YW-1:0] y_h [NCH][NTAP_Y];

  assign acc_en = running_q & sample_valid_i;
  assign u_now  = $signed({1'b0, ref_code_i}) - $signed({1'b0, sample_i});

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic we;
    assign we = acc_en && (chan_sel_i == 1'(ch));
    lc3_history #(.UW(UW), .YW(YW)) u_hist (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .u_i     (u_now),
      .y_i     (y_new),
      .u_hist_o(u_h[ch]),
      .y_hist_o(y_h[ch])
    );
  end

  lc3_mac #(.UW(UW), .YW(YW), .FRAC(FRAC), .AW(AW)) u_mac (
    .u_i     (u_now),
    .u_hist_i(u_h[chan_sel_i]),
    .y_hist_i(y_h[chan_sel_i]),
    .y_o     (y_new)
  );

  lc3_clamp #(.DW(DW), .YW(YW), .FRAC(FRAC)) u_clamp (
    .y_i   (y_new),
    .ref_i (ref_code_i),
    .hi_i  (lim_hi_i),
    .lo_i  (lim_lo_i),
    .duty_o(duty_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      duty_o    <= '0;
    end else begin
      running_q <= running_q | start_i;
      if (!running_q)  duty_o <= ref_code_i;
      else if (acc_en) duty_o <= duty_d;
    end
  end
endmodule

// File: rtl/lc3_checker.sv
module lc3_checker #(
  parameter int unsigned DW = 6,
  parameter int unsigned YW = 22
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 running,
  input logic                 acc_en,
  input logic                 chan_sel,
  input logic        [DW-1:0] ref_code,
  input logic        [DW-1:0] lim_hi,
  input logic        [DW-1:0] lim_lo,
  input logic        [DW-1:0] duty,
  input logic signed [YW-1:0] y_c0,
  input logic signed [YW-1:0] y_c1
);
  p_hold_ref_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |=> duty == $past(ref_code));

  p_sticky_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |=> running);

  p_iso_ch0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en && !chan_sel) |=> $stable(y_c1));

  p_iso_ch1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en && chan_sel) |=> $stable(y_c0));

  p_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en && lim_lo <= lim_hi) |=> (duty <= $past(lim_hi) && duty >= $past(lim_lo)));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !acc_en) |=> $stable(duty));
endmodule

bind loop_comp3 lc3_checker #(.DW(DW), .YW(YW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .running (running_q),
  .acc_en  (acc_en),
  .chan_sel(chan_sel_i),
  .ref_code(ref_code_i),
  .lim_hi  (lim_hi_i),
  .lim_lo  (lim_lo_i),
  .duty    (duty_o),
  .y_c0    (y_h[0][0]),
  .y_c1    (y_h[1][0])
);

// File: tb/sim_loop_comp3.sv
module sim_loop_comp3;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       sel = 1'b0;
  logic       valid = 1'b0;
  logic [5:0] smp = '0;
  logic [5:0] ref_c = 6'd20;
  logic [5:0] hi = 6'd63;
  logic [5:0] lo = 6'd0;
  logic [5:0] duty;

  int    n_chk = 0;
  int    n_err = 0;
  bit    chk_en = 1'b0;
  bit    done = 1'b0;
  string phase = "R1";

  always #5 clk = ~clk;

  loop_comp3 u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_sel_i(sel),
    .sample_valid_i(valid), .sample_i(smp), .ref_code_i(ref_c),
    .lim_hi_i(hi), .lim_lo_i(lo), .duty_o(duty)
  );

  // behavioural reference model
  longint bc [4] = '{12227, -11043, -12200, 11072};
  longint ac [3] = '{8038, -4890, 948};
  longint uh [2][3];
  longint yh [2][3];
  bit     run = 1'b0;
  int     exp_duty = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      run = 1'b0;
      exp_duty = 0;
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < 3; k++) begin
          uh[c][k] = 0;
          yh[c][k] = 0;
        end
    end else begin
      if (!run) exp_duty = int'(ref_c);
      else if (valid) begin
        int c;
        longint u, acc, fb, v;
        c = int'(sel);
        u = longint'(ref_c) - longint'(smp);
        acc = bc[0]*u + bc[1]*uh[c][0] + bc[2]*uh[c][1] + bc[3]*uh[c][2];
        fb  = ac[0]*yh[c][0] + ac[1]*yh[c][1] + ac[2]*yh[c][2];
        acc = acc + (fb >>> 12);
        if (acc > 2097151) acc = 2097151;
        if (acc < -2097152) acc = -2097152;
        uh[c][2] = uh[c][1]; uh[c][1] = uh[c][0]; uh[c][0] = u;
        yh[c][2] = yh[c][1]; yh[c][1] = yh[c][0]; yh[c][0] = acc;
        v = longint'(ref_c) + (acc >>> 12);
        if (v > longint'(hi))      exp_duty = int'(hi);
        else if (v < longint'(lo)) exp_duty = int'(lo);
        else                       exp_duty = int'(v);
      end
      if (start) run = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      n_chk++;
      if (int'(duty) != exp_duty) begin
        n_err++;
        $display("FAIL %s duty_o=%0d expected=%0d t=%0t", phase, duty, exp_duty, $time);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic cyc(input bit v, input bit s, input logic [5:0] d);
    valid = v; sel = s; smp = d;
    @(negedge clk);
  endtask

  int unsigned seed = 32'h1234_5678;
  function automatic logic [5:0] nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[21:16];
  endfunction

  task automatic do_reset();
    chk_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(duty == 6'd0, "R1 reset duty", int'(duty), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_en = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    phase = "R1"; do_reset();

    // R2: samples before start must not touch history
    phase = "R2";
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'(i), nxt());
    ref_c = 6'd25;
    cyc(1'b0, 1'b0, 6'd0);
    check(duty == 6'd25, "R2 ref echo", int'(duty), 25);

    // R3: start, then hold until first sample
    phase = "R3";
    start = 1'b1; cyc(1'b0, 1'b0, 6'd0); start = 1'b0;
    ref_c = 6'd30;
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 6'd0);
    check(duty == 6'd25, "R3 hold after start", int'(duty), 25);

    // R4 R5 R6 R8: alternating channels, varied samples
    phase = "R5";
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'(i), nxt());
    phase = "R4";
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'(i), (i % 2) ? 6'd28 : 6'd33);
    // R10: gaps between samples
    phase = "R10";
    for (int i = 0; i < 30; i++) begin
      cyc(1'b1, 1'(i), nxt());
      cyc(1'b0, 1'(i), nxt());
      cyc(1'b0, 1'(~i), nxt());
    end
    // R6: long run on channel 0 only, then channel 1
    phase = "R6";
    for (int i = 0; i < 25; i++) cyc(1'b1, 1'b0, nxt());
    for (int i = 0; i < 25; i++) cyc(1'b1, 1'b1, nxt());

    // R9: narrow window and inverted window
    phase = "R9";
    hi = 6'd40; lo = 6'd10;
    for (int i = 0; i < 60; i++) cyc(1'b1, 1'(i), nxt());
    hi = 6'd20; lo = 6'd50;
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'(i), nxt());
    check(duty == 6'd20 || duty == 6'd50, "R9 inverted window", int'(duty), 20);
    hi = 6'd63; lo = 6'd0;

    // R7: constant error drives the integrator into saturation, then reverse
    phase = "R7";
    ref_c = 6'd63;
    for (int i = 0; i < 1600; i++) cyc(1'b1, 1'(i), 6'd0);
    check(duty == 6'd63, "R7 saturated high", int'(duty), 63);
    ref_c = 6'd0;
    for (int i = 0; i < 1600; i++) cyc(1'b1, 1'(i), 6'd63);
    check(duty == 6'd0, "R7 saturated low", int'(duty), 0);
    ref_c = 6'd32;
    for (int i = 0; i < 60; i++) cyc(1'b1, 1'(i), nxt());

    // R1: reset mid-run clears everything, R3 start again
    phase = "R1";
    do_reset();
    ref_c = 6'd18;
    cyc(1'b0, 1'b0, 6'd0);
    check(duty == 6'd18, "R2 after reset", int'(duty), 18);
    phase = "R3";
    start = 1'b1; cyc(1'b0, 1'b0, 6'd0); start = 1'b0;
    phase = "R8";
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'(i), nxt());

    chk_en = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule